// File: doc/BRIEF.md
# MMU Control Register File

This block is a bank of nine 32-bit memory-management and exception registers on a simple CPU-side register bus. It holds the translation control word, the page-table entry high, low and assist words, the translation table base, the faulting address, the trap code and the two event codes (exception and interrupt). Several registers act on the write itself. Setting the invalidate bit in the control word asks an external translation buffer to drop every entry. Changing the address-space ID held in the low byte of the page-table entry high word asks that buffer to flush. Both requests leave the block as single-cycle pulses.

Software reaches the bank with word accesses only. Each access is a single-cycle strobe that carries an address, a direction, a size code and write data. The read data and the error flag are returned in the same cycle. A write takes effect at the clock edge that ends the access. Every stored value is also driven out on its own port, so the translation logic and the exception logic can use it without going through the bus.

Top module: `mmu_ctl_regfile`

## Requirements
- R1: While reset is held, and after it is released, every register output and both pulses read zero. A write presented during reset changes nothing and raises no pulse.
- R2: A word write to the control word (offset 0x00) with bit 2 set drives `tlb_inval_pulse` high for exactly the one cycle after the write edge. The stored word keeps every other bit of the write, and bit 2 always reads back as zero. A write with bit 2 clear raises no pulse.
- R3: A word write to the entry-high word (offset 0x04) stores all 32 bits. If bits 7:0 of the write differ from the stored bits 7:0, `tlb_flush_pulse` is high for the one cycle after the write edge. If they are equal, no pulse is raised.
- R4: The entry-assist word (offset 0x20) keeps only bits 3:0 of a write. Its other bits read zero.
- R5: The trap code (0x14), exception code (0x18) and interrupt code (0x1C) words keep only bits 10:0 of a write. Their other bits read zero.
- R6: The entry-low (0x08), table base (0x0C) and fault address (0x10) words store all 32 bits of a write.
- R7: A word read returns the stored value on `bus_rdata` in the access cycle. A read changes no state and raises no pulse.
- R8: An access whose size code is not word (size 0 = byte, 1 = half, 3 = reserved; 2 = word) raises `bus_err` in the access cycle. It changes no register and raises no pulse.
- R9: An access to an offset with bits 1:0 non-zero, or to any offset above 0x20, raises `bus_err` in the access cycle. It changes no register and raises no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_valid | input | 1 | Access strobe, one cycle per access |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_size | input | 2 | Size code: 0 byte, 1 half, 2 word, 3 reserved |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the access cycle |
| bus_err | output | 1 | Error response, valid in the access cycle |
| mmu_ctl_q | output | 32 | Translation control word |
| pte_hi_q | output | 32 | Page-table entry high word (ASID in 7:0) |
| pte_lo_q | output | 32 | Page-table entry low word |
| pte_assist_q | output | 32 | Page-table entry assist word |
| tbl_base_q | output | 32 | Translation table base |
| fault_addr_q | output | 32 | Faulting address |
| trap_code_q | output | 32 | Trap code |
| exc_code_q | output | 32 | Exception event code |
| irq_code_q | output | 32 | Interrupt event code |
| tlb_inval_pulse | output | 1 | Invalidate-all request to the translation buffer |
| tlb_flush_pulse | output | 1 | Flush request after an address-space change |

## Verification
The error flag and the read data are combinational, so they are due in the access cycle itself. The bench samples them one time unit after it drives the access on a falling edge. Register outputs and both maintenance pulses come from flops loaded at the rising edge that ends the access. The bench samples them at the next falling edge. It then samples the pulses again one cycle later and expects them low, which proves each pulse lasts exactly one cycle. After every rejected access, the bench compares all nine register outputs and both pulses with its own model.

// File: rtl/mmu_ctl_pkg.sv
package mmu_ctl_pkg;

  localparam int DATA_W   = 32;
  localparam int NREG     = 9;
  localparam int ASID_W   = 8;
  localparam int EVT_W    = 11;
  localparam int ASSIST_W = 4;
  localparam int INV_BIT  = 2;

  // register index; byte offset = index * 4
  typedef enum logic [3:0] {
    IDX_CTL   = 4'd0,
    IDX_PTEH  = 4'd1,
    IDX_PTEL  = 4'd2,
    IDX_TTB   = 4'd3,
    IDX_FAULT = 4'd4,
    IDX_TRAP  = 4'd5,
    IDX_EXC   = 4'd6,
    IDX_IRQ   = 4'd7,
    IDX_PTEA  = 4'd8
  } reg_idx_e;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_RSVD = 2'd3
  } acc_size_e;

  // bits of a write that each register retains
  function automatic logic [DATA_W-1:0] keep_mask(input int idx);
    logic [DATA_W-1:0] m;
    m = '1;
    if (idx == int'(IDX_CTL)) begin
      m = ~(DATA_W'(1) << INV_BIT);
    end else if (idx == int'(IDX_PTEA)) begin
      m = (DATA_W'(1) << ASSIST_W) - DATA_W'(1);
    end else if (idx == int'(IDX_TRAP) || idx == int'(IDX_EXC) || idx == int'(IDX_IRQ)) begin
      m = (DATA_W'(1) << EVT_W) - DATA_W'(1);
    end
    return m;
  endfunction

endpackage

// File: rtl/mmu_ctl_rst_sync.sv
module mmu_ctl_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q    <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      stage_q    <= 1'b1;
      rst_sync_n <= stage_q;
    end
  end

endmodule

// File: rtl/mmu_ctl_decode.sv
module mmu_ctl_decode
  import mmu_ctl_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int N      = NREG,
  localparam int IDX_W = ADDR_W - 2
) (
  input  logic              valid,
  input  logic              write,
  input  logic [ADDR_W-1:0] addr,
  input  logic [1:0]        size,
  output logic [N-1:0]      wr_sel,
  output logic              rd_ok,
  output logic [IDX_W-1:0]  rd_idx,
  output logic              err
);

  logic             aligned;
  logic             mapped;
  logic             size_ok;
  logic             acc_ok;
  logic [IDX_W-1:0] idx;

  always_comb begin
    idx     = addr[ADDR_W-1:2];
    aligned = (addr[1:0] == 2'b00);
    mapped  = aligned && (idx < IDX_W'(N));
    size_ok = (size == SZ_WORD);
    acc_ok  = valid && mapped && size_ok;
    err     = valid && !(mapped && size_ok);
    rd_ok   = acc_ok && !write;
    rd_idx  = idx;
  end

  for (genvar i = 0; i < N; i++) begin : g_sel
    assign wr_sel[i] = acc_ok && write && (idx == IDX_W'(i));
  end

endmodule

// File: rtl/mmu_ctl_field.sv
module mmu_ctl_field #(
  parameter int           W    = 32,
  parameter logic [W-1:0] KEEP = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] q
);

  logic [W-1:0] q_d;

  always_comb begin
    q_d = q;
    if (wr_en) q_d = wdata & KEEP;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     q <= '0;
    else if (wr_en) q <= q_d;
  end

  // R4 R5 R6: a write lands as the data restricted to the kept bits
  assert_write_kept_bits_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (q == ($past(wdata) & KEEP)));

  assert_hold_no_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(q));

endmodule

// File: rtl/mmu_ctl_maint.sv
module mmu_ctl_maint #(
  parameter int ASID_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_ctl,
  input  logic              inv_bit,
  input  logic              wr_pteh,
  input  logic [ASID_W-1:0] new_asid,
  input  logic [ASID_W-1:0] cur_asid,
  output logic              inval_pulse,
  output logic              flush_pulse
);

  logic inval_d;
  logic flush_d;

  always_comb begin
    inval_d = wr_ctl && inv_bit;
    flush_d = wr_pteh && (new_asid != cur_asid);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      inval_pulse <= 1'b0;
      flush_pulse <= 1'b0;
    end else begin
      inval_pulse <= inval_d;
      flush_pulse <= flush_d;
    end
  end

  assert_inval_follows_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ctl && inv_bit) |=> inval_pulse);

  assert_inval_has_cause_R2: assert property (@(posedge clk) disable iff (!rst_n)
    inval_pulse |-> $past(wr_ctl));

  assert_flush_on_asid_change_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_pteh && (new_asid != cur_asid)) |=> flush_pulse);

  assert_no_flush_same_asid_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_pteh && (new_asid == cur_asid)) |=> !flush_pulse);

  assert_flush_has_cause_R3: assert property (@(posedge clk) disable iff (!rst_n)
    flush_pulse |-> $past(wr_pteh));

endmodule

// File: rtl/mmu_ctl_regfile.sv
module mmu_ctl_regfile
  import mmu_ctl_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [1:0]        bus_size,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              bus_err,
  output logic [31:0]       mmu_ctl_q,
  output logic [31:0]       pte_hi_q,
  output logic [31:0]       pte_lo_q,
  output logic [31:0]       pte_assist_q,
  output logic [31:0]       tbl_base_q,
  output logic [31:0]       fault_addr_q,
  output logic [31:0]       trap_code_q,
  output logic [31:0]       exc_code_q,
  output logic [31:0]       irq_code_q,
  output logic              tlb_inval_pulse,
  output logic              tlb_flush_pulse
);

  localparam int IDX_W  = ADDR_W - 2;
  localparam int FLAT_W = NREG * DATA_W;

  logic              rst_sync_n;
  logic [NREG-1:0]   wr_sel;
  logic              rd_ok;
  logic [IDX_W-1:0]  rd_idx;
  logic [DATA_W-1:0] regq [NREG];
  logic [FLAT_W-1:0] all_q;

  mmu_ctl_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  mmu_ctl_decode #(.ADDR_W(ADDR_W), .N(NREG)) u_dec (
    .valid  (bus_valid),
    .write  (bus_write),
    .addr   (bus_addr),
    .size   (bus_size),
    .wr_sel (wr_sel),
    .rd_ok  (rd_ok),
    .rd_idx (rd_idx),
    .err    (bus_err)
  );

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    mmu_ctl_field #(.W(DATA_W), .KEEP(keep_mask(i))) u_fld (
      .clk   (clk),
      .rst_n (rst_sync_n),
      .wr_en (wr_sel[i]),
      .wdata (bus_wdata),
      .q     (regq[i])
    );
    assign all_q[i*DATA_W +: DATA_W] = regq[i];
  end

  mmu_ctl_maint #(.ASID_W(ASID_W)) u_maint (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .wr_ctl      (wr_sel[IDX_CTL]),
    .inv_bit     (bus_wdata[INV_BIT]),
    .wr_pteh     (wr_sel[IDX_PTEH]),
    .new_asid    (bus_wdata[ASID_W-1:0]),
    .cur_asid    (regq[IDX_PTEH][ASID_W-1:0]),
    .inval_pulse (tlb_inval_pulse),
    .flush_pulse (tlb_flush_pulse)
  );

  always_comb begin
    bus_rdata = '0;
    for (int i = 0; i < NREG; i++) begin
      if (rd_ok && (rd_idx == IDX_W'(i))) bus_rdata = regq[i];
    end
  end

  assign mmu_ctl_q    = regq[IDX_CTL];
  assign pte_hi_q     = regq[IDX_PTEH];
  assign pte_lo_q     = regq[IDX_PTEL];
  assign tbl_base_q   = regq[IDX_TTB];
  assign fault_addr_q = regq[IDX_FAULT];
  assign trap_code_q  = regq[IDX_TRAP];
  assign exc_code_q   = regq[IDX_EXC];
  assign irq_code_q   = regq[IDX_IRQ];
  assign pte_assist_q = regq[IDX_PTEA];

  assert_inval_never_stored_R2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    mmu_ctl_q[INV_BIT] == 1'b0);

  assert_err_no_update_R8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    bus_err |=> ($stable(all_q) && !tlb_inval_pulse && !tlb_flush_pulse));

  assert_single_write_sel_R9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $onehot0(wr_sel));

  assert_read_no_pulse_R7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (bus_valid && !bus_write) |=> (!tlb_inval_pulse && !tlb_flush_pulse));

endmodule

// File: tb/sim_mmu_ctl_regfile.sv
module sim_mmu_ctl_regfile;

  localparam int CLK_PERIOD = 10;
  localparam int NR = 9;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_valid, bus_write;
  logic [7:0]  bus_addr;
  logic [1:0]  bus_size;
  logic [31:0] bus_wdata, bus_rdata;
  logic        bus_err;
  logic [31:0] q_ctl, q_hi, q_lo, q_as, q_tb, q_fa, q_tr, q_ex, q_ir;
  logic        p_inv, p_fl;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  logic [31:0] model [NR];
  logic [31:0] obs   [NR];

  always #(CLK_PERIOD/2) clk = ~clk;

  mmu_ctl_regfile #(.ADDR_W(8)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_size(bus_size), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .bus_err(bus_err),
    .mmu_ctl_q(q_ctl), .pte_hi_q(q_hi), .pte_lo_q(q_lo), .pte_assist_q(q_as),
    .tbl_base_q(q_tb), .fault_addr_q(q_fa), .trap_code_q(q_tr),
    .exc_code_q(q_ex), .irq_code_q(q_ir),
    .tlb_inval_pulse(p_inv), .tlb_flush_pulse(p_fl)
  );

  // offset/4 order: ctl, hi, lo, base, fault, trap, exc, irq, assist
  always_comb begin
    obs[0] = q_ctl; obs[1] = q_hi; obs[2] = q_lo; obs[3] = q_tb; obs[4] = q_fa;
    obs[5] = q_tr;  obs[6] = q_ex; obs[7] = q_ir; obs[8] = q_as;
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  task automatic chk_all(input string tag);
    for (int i = 0; i < NR; i++) chk(obs[i] === model[i], tag, obs[i], model[i]);
  endtask

  // drive one access at a falling edge; returns at the next falling edge
  task automatic access(input logic wr, input logic [7:0] a, input logic [1:0] sz,
                        input logic [31:0] d, output logic err, output logic [31:0] rd);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = wr; bus_addr = a; bus_size = sz; bus_wdata = d;
    #1;
    err = bus_err; rd = bus_rdata;
    @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0;
  endtask

  task automatic wr_chk(input logic [7:0] a, input logic [31:0] d, input logic [31:0] keep,
                        input logic exp_inv, input logic exp_fl, input string tag);
    logic e; logic [31:0] r;
    access(1'b1, a, 2'd2, d, e, r);
    chk(e === 1'b0, {tag, " err"}, 32'(e), 0);
    model[a >> 2] = d & keep;
    chk_all({tag, " stored"});
    chk(p_inv === exp_inv, {tag, " inval pulse"}, 32'(p_inv), 32'(exp_inv));
    chk(p_fl === exp_fl, {tag, " flush pulse"}, 32'(p_fl), 32'(exp_fl));
    @(negedge clk);
    chk(p_inv === 1'b0 && p_fl === 1'b0, {tag, " pulse width"}, {30'd0, p_inv, p_fl}, 0);
  endtask

  task automatic bad_chk(input logic wr, input logic [7:0] a, input logic [1:0] sz,
                         input logic [31:0] d, input string tag);
    logic e; logic [31:0] r;
    access(wr, a, sz, d, e, r);
    chk(e === 1'b1, {tag, " err"}, 32'(e), 1);
    chk_all({tag, " unchanged"});
    chk(p_inv === 1'b0 && p_fl === 1'b0, {tag, " no pulse"}, {30'd0, p_inv, p_fl}, 0);
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    bus_valid = 1'b0; bus_write = 1'b0; bus_addr = '0; bus_size = 2'd2; bus_wdata = '0;
    for (int i = 0; i < NR; i++) model[i] = '0;
    repeat (2) @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b1; bus_addr = 8'h00; bus_wdata = 32'hFFFF_FFFF;
    repeat (2) @(negedge clk);
    chk_all("R1 during reset");
    chk(p_inv === 1'b0 && p_fl === 1'b0, "R1 no pulse in reset", {30'd0, p_inv, p_fl}, 0);
    bus_valid = 1'b0; bus_write = 1'b0;
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk_all("R1 after release");
    chk(p_inv === 1'b0 && p_fl === 1'b0, "R1 pulses idle", {30'd0, p_inv, p_fl}, 0);
  endtask

  task automatic t_full_width;
    wr_chk(8'h08, 32'hDEAD_BEEF, 32'hFFFF_FFFF, 0, 0, "R6 entry low");
    wr_chk(8'h0C, 32'h1234_5678, 32'hFFFF_FFFF, 0, 0, "R6 table base");
    wr_chk(8'h10, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 0, 0, "R6 fault addr");
  endtask

  task automatic t_narrow;
    wr_chk(8'h20, 32'hFFFF_FFFF, 32'h0000_000F, 0, 0, "R4 assist");
    wr_chk(8'h14, 32'hFFFF_FFFF, 32'h0000_07FF, 0, 0, "R5 trap");
    wr_chk(8'h18, 32'hABCD_E923, 32'h0000_07FF, 0, 0, "R5 exception");
    wr_chk(8'h1C, 32'h0000_0FFF, 32'h0000_07FF, 0, 0, "R5 interrupt");
  endtask

  task automatic t_inval;
    wr_chk(8'h00, 32'h8000_0105, 32'hFFFF_FFFB, 1, 0, "R2 inval set");
    wr_chk(8'h00, 32'h0000_0001, 32'hFFFF_FFFB, 0, 0, "R2 inval clear");
    wr_chk(8'h00, 32'h0000_0004, 32'hFFFF_FFFB, 1, 0, "R2 inval only");
  endtask

  task automatic t_flush;
    wr_chk(8'h04, 32'h0000_0012, 32'hFFFF_FFFF, 0, 1, "R3 asid change");
    wr_chk(8'h04, 32'hABCD_0012, 32'hFFFF_FFFF, 0, 0, "R3 asid same");
    wr_chk(8'h04, 32'hABCD_0013, 32'hFFFF_FFFF, 0, 1, "R3 asid bit0");
    wr_chk(8'h04, 32'h0000_0013, 32'hFFFF_FFFF, 0, 0, "R3 upper only");
  endtask

  task automatic t_read;
    logic e; logic [31:0] r;
    for (int i = 0; i < NR; i++) begin
      access(1'b0, 8'(i * 4), 2'd2, 32'hFFFF_FFFF, e, r);
      chk(e === 1'b0 && r === model[i], "R7 read data", r, model[i]);
      chk(p_inv === 1'b0 && p_fl === 1'b0, "R7 read no pulse", {30'd0, p_inv, p_fl}, 0);
    end
    chk_all("R7 read no change");
  endtask

  task automatic t_bad_size;
    bad_chk(1'b1, 8'h08, 2'd0, 32'h0, "R8 byte write");
    bad_chk(1'b1, 8'h00, 2'd1, 32'h4, "R8 half write inval");
    bad_chk(1'b1, 8'h04, 2'd3, 32'h55, "R8 reserved size flush");
    bad_chk(1'b0, 8'h0C, 2'd0, 32'h0, "R8 byte read");
  endtask

  task automatic t_unmapped;
    bad_chk(1'b1, 8'h24, 2'd2, 32'hFFFF_FFFF, "R9 past end");
    bad_chk(1'b1, 8'h06, 2'd2, 32'h0000_0077, "R9 misaligned");
    bad_chk(1'b1, 8'h01, 2'd2, 32'h0000_0004, "R9 misaligned ctl");
    bad_chk(1'b0, 8'hFC, 2'd2, 32'h0, "R9 top read");
  endtask

  initial begin
    t_reset();
    t_full_width();
    t_narrow();
    t_inval();
    t_flush();
    t_read();
    t_bad_size();
    t_unmapped();
    t_read();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule